// File: doc/BRIEF.md
# Dual-Clock Frame Offload Controller

The block sits between a streaming source and a streaming destination that run on unrelated clocks, and sequences a dual-port buffer RAM that lives outside it. On the source clock it turns every accepted beat into a registered write strobe, address, data word and end-of-frame flag for the RAM's write port. When the frame is complete it carries the final write address and the byte mask of the final beat across to the destination clock. On the destination clock it then issues read strobes and addresses, and it presents the RAM's read data as a stream with last and keep attached. It plays the frame out once, or in an endless loop.

One parameter picks the transmit or the receive flavour. The transmit flavour may loop when the cyclic parameter is set. The receive flavour always plays one copy per capture, whatever the cyclic parameter says. Capture is armed by a one-cycle `start_req` pulse. With the auto-start parameter set, the block also comes out of reset already armed. A source that cannot be stalled is served because `s_ready` is high for the whole capture. A destination that cannot stall simply holds `m_ready` high.

The fill engine has three states. FILL_IDLE moves to FILL_RUN on `start_req`. FILL_RUN moves to FILL_SYNC on the frame's final beat. FILL_SYNC moves to FILL_IDLE once the clock-crossing handshake has been acknowledged. The reset state is FILL_RUN when auto-start is set and FILL_IDLE otherwise. The play engine also has three states. PLAY_IDLE moves to PLAY_RUN when a handed-over frame is pending. In one-shot operation, PLAY_RUN moves to PLAY_DRAIN when it issues the read of the final address. PLAY_DRAIN moves to PLAY_IDLE when that beat is accepted. In cyclic operation PLAY_RUN stays put and the read address wraps to zero.

Top module: `offload_ctrl`

## Requirements
- R1: Right after reset, `s_ready` is 1 if AUTO_START is set and 0 otherwise. `m_valid`, `mem_wr_en` and `mem_rd_en` are all 0.
- R2: Each beat accepted on the source (`s_valid` and `s_ready` both high at a source clock edge) gives exactly one `mem_wr_en` pulse on the following cycle. That pulse carries the beat's data, and addresses count up from 0 within a frame.
- R3: `mem_wr_last` is 1 on the write of the frame's final beat, and 0 on every other write.
- R4: After the final beat, `s_ready` stays 0 until a `start_req` pulse arrives. The pulse sets `s_ready` to 1 on the next cycle, and the next frame starts again at address 0.
- R5: A beat written to the top address (all ones) ends the frame even without `s_last`. Its write carries `mem_wr_last`, and no further beat is accepted.
- R6: Reads begin only after the handover has completed. Reads cover addresses 0 up to the final write address in order, and each output beat equals the word stored there.
- R7: `m_keep` equals the `s_keep` of the frame's final beat on the beat that carries `m_last`, and is all ones on every other beat.
- R8: In one-shot operation, after the beat with `m_last` has been accepted, `m_valid` stays 0 and no further reads are issued until a new frame has been handed over.
- R9: With TX_PATH=1 and CYCLIC_EN=1, playback wraps from the final address back to 0 without end, and `m_last` is raised on every final beat.
- R10: With TX_PATH=0, each captured frame plays exactly once even when CYCLIC_EN=1.
- R11: While `m_valid` is 1 and `m_ready` is 0, the beat is held (valid, data, last and keep unchanged). `mem_rd_en` stays 0 while `mem_rd_rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Source clock |
| s_rstn | input | 1 | Source-domain reset, active low |
| start_req | input | 1 | One-cycle pulse that arms a capture |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | High while capturing |
| s_data | input | DATA_W | Source beat data |
| s_keep | input | DATA_W/8 | Byte mask of the source beat |
| s_last | input | 1 | Final beat of the frame |
| mem_wr_rstn | output | 1 | Reset to the RAM write port, active low |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wr_addr | output | ADDR_W | RAM write address |
| mem_wr_data | output | DATA_W | RAM write data |
| mem_wr_last | output | 1 | Marks the frame's final write |
| m_clk | input | 1 | Destination clock |
| m_rstn | input | 1 | Destination-domain reset, active low |
| m_valid | output | 1 | Destination beat valid |
| m_ready | input | 1 | Destination accepts the beat |
| m_data | output | DATA_W | Destination beat data (RAM read data) |
| m_keep | output | DATA_W/8 | Byte mask of the destination beat |
| m_last | output | 1 | Final beat of one frame copy |
| mem_rd_rstn | output | 1 | Reset to the RAM read port, active low |
| mem_rd_en | output | 1 | RAM read strobe; the RAM holds its output while this is low |
| mem_rd_rdy | input | 1 | RAM can take a read request |
| mem_rd_addr | output | ADDR_W | RAM read address |
| mem_rd_data | input | DATA_W | RAM read data, one cycle after the strobe |

## Verification
Two instances run side by side. One is transmit, looping and auto-started. The other is receive and armed by request. Both carry random payload and keep values, random gaps in the source valid, and random stalls on the destination ready and on the RAM read-ready. The looping instance gets one partial-keep frame and must repeat it with the right last and keep every time. This separates a correct wrap from a stop or an off-by-one. The receive instance gets a one-beat frame, random-length frames, and an overrun of twenty beats with no last. These separate a correct one-shot stop, the forced end at the top of memory, and re-arming from a stuck or looping engine.

// File: rtl/offload_pkg.sv
package offload_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_RUN  = 2'd1,
        FILL_SYNC = 2'd2
    } fill_state_e;

    typedef enum logic [1:0] {
        PLAY_IDLE  = 2'd0,
        PLAY_RUN   = 2'd1,
        PLAY_DRAIN = 2'd2
    } play_state_e;

endpackage

// File: rtl/offload_fill.sv
module offload_fill
    import offload_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int KEEP_W     = 8,
    parameter int ADDR_W     = 8,
    parameter bit AUTO_START = 1'b0
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic              start_req,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [KEEP_W-1:0] s_keep,
    input  logic              s_last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [KEEP_W-1:0] push_keep,
    input  logic              hs_busy
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
    localparam fill_state_e BOOT_ST = AUTO_START ? FILL_RUN : FILL_IDLE;

    fill_state_e       state, state_nx;
    logic [ADDR_W-1:0] waddr;
    logic              take;
    logic              frame_end;

    // state register
    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) state <= BOOT_ST;
        else       state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FILL_IDLE: if (start_req) state_nx = FILL_RUN;
            FILL_RUN:  if (frame_end) state_nx = FILL_SYNC;
            FILL_SYNC: if (!hs_busy)  state_nx = FILL_IDLE;
            default:   state_nx = FILL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_ready   = (state == FILL_RUN);
        take      = s_valid && s_ready;
        frame_end = take && (s_last || (waddr == TOP_ADDR));
        push      = frame_end;
        push_addr = waddr;
        push_keep = s_keep;
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            waddr   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_last <= 1'b0;
        end else begin
            wr_en <= take;
            if (take) begin
                wr_addr <= waddr;
                wr_data <= s_data;
                wr_last <= frame_end;
            end
            if (state != FILL_RUN) waddr <= '0;
            else if (take)         waddr <= waddr + 1'b1;
        end
    end

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rstn)
        (wr_en && $past(wr_en) && !$past(wr_last)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    assert_stall_after_last_R4: assert property (@(posedge clk) disable iff (!rstn)
        (wr_en && wr_last) |-> !s_ready);

endmodule

// File: rtl/offload_xfer_sync.sv
module offload_xfer_sync #(
    parameter int ADDR_W = 8,
    parameter int KEEP_W = 8
) (
    input  logic              s_clk,
    input  logic              s_rstn,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [KEEP_W-1:0] push_keep,
    output logic              busy,
    input  logic              m_clk,
    input  logic              m_rstn,
    output logic              frame_new,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [KEEP_W-1:0] frame_keep
);

    logic              req_t;
    logic [ADDR_W-1:0] hold_addr;
    logic [KEEP_W-1:0] hold_keep;
    logic              ack_s1, ack_s2;
    logic              req_m1, req_m2, seen;

    // source side: toggle request, hold payload until acknowledged
    always_ff @(posedge s_clk or negedge s_rstn) begin
        if (!s_rstn) begin
            req_t     <= 1'b0;
            hold_addr <= '0;
            hold_keep <= '0;
            ack_s1    <= 1'b0;
            ack_s2    <= 1'b0;
        end else begin
            ack_s1 <= seen;
            ack_s2 <= ack_s1;
            if (push) begin
                req_t     <= ~req_t;
                hold_addr <= push_addr;
                hold_keep <= push_keep;
            end
        end
    end

    always_comb busy = req_t ^ ack_s2;

    // destination side: two-flop sync, edge detect, capture
    always_ff @(posedge m_clk or negedge m_rstn) begin
        if (!m_rstn) begin
            req_m1     <= 1'b0;
            req_m2     <= 1'b0;
            seen       <= 1'b0;
            frame_new  <= 1'b0;
            frame_addr <= '0;
            frame_keep <= '0;
        end else begin
            req_m1    <= req_t;
            req_m2    <= req_m1;
            seen      <= req_m2;
            frame_new <= req_m2 ^ seen;
            if (req_m2 ^ seen) begin
                frame_addr <= hold_addr;
                frame_keep <= hold_keep;
            end
        end
    end

    assert_hold_stable_R6: assert property (@(posedge s_clk) disable iff (!s_rstn)
        (busy && $past(busy)) |-> ($stable(hold_addr) && $stable(hold_keep)));

endmodule

// File: rtl/offload_play.sv
module offload_play
    import offload_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int KEEP_W = 8,
    parameter bit CYCLIC = 1'b0
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic              frame_new,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [KEEP_W-1:0] frame_keep,
    input  logic              m_ready,
    output logic              m_valid,
    output logic              m_last,
    output logic [KEEP_W-1:0] m_keep,
    input  logic              rd_rdy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);

    play_state_e       state, state_nx;
    logic              pend;
    logic [ADDR_W-1:0] nxt_last, cur_last, raddr;
    logic [KEEP_W-1:0] nxt_keep, cur_keep, out_keep;
    logic              out_vld, out_last;
    logic              slot_free, at_end, adopt;

    // state register
    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) state <= PLAY_IDLE;
        else       state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PLAY_IDLE:  if (pend) state_nx = PLAY_RUN;
            PLAY_RUN:   if (rd_en && at_end && !CYCLIC) state_nx = PLAY_DRAIN;
            PLAY_DRAIN: if (slot_free) state_nx = PLAY_IDLE;
            default:    state_nx = PLAY_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        slot_free = !out_vld || m_ready;
        at_end    = (raddr == cur_last);
        rd_en     = (state == PLAY_RUN) && rd_rdy && slot_free;
        rd_addr   = raddr;
        adopt     = pend && ((state == PLAY_IDLE) || (CYCLIC && rd_en && at_end));
        m_valid   = out_vld;
        m_last    = out_last;
        m_keep    = out_keep;
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            pend     <= 1'b0;
            nxt_last <= '0;
            nxt_keep <= '0;
            cur_last <= '0;
            cur_keep <= '0;
            raddr    <= '0;
            out_vld  <= 1'b0;
            out_last <= 1'b0;
            out_keep <= '0;
        end else begin
            if (frame_new) begin
                pend     <= 1'b1;
                nxt_last <= frame_addr;
                nxt_keep <= frame_keep;
            end else if (adopt) begin
                pend <= 1'b0;
            end
            if (adopt) begin
                cur_last <= nxt_last;
                cur_keep <= nxt_keep;
            end
            if (adopt)      raddr <= '0;
            else if (rd_en) raddr <= at_end ? '0 : raddr + 1'b1;
            if (rd_en) begin
                out_vld  <= 1'b1;
                out_last <= at_end;
                out_keep <= at_end ? cur_keep : '1;
            end else if (m_ready) begin
                out_vld <= 1'b0;
            end
        end
    end

    assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rstn)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_last) && $stable(m_keep)));

    assert_once_stop_R8: assert property (@(posedge clk) disable iff (!rstn)
        (!CYCLIC && m_valid && m_ready && m_last) |=> !m_valid);

endmodule

// File: rtl/offload_ctrl.sv
module offload_ctrl
    import offload_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 8,
    parameter bit TX_PATH    = 1'b1,
    parameter bit CYCLIC_EN  = 1'b0,
    parameter bit AUTO_START = 1'b0
) (
    input  logic                  s_clk,
    input  logic                  s_rstn,
    input  logic                  start_req,
    input  logic                  s_valid,
    output logic                  s_ready,
    input  logic [DATA_W-1:0]     s_data,
    input  logic [DATA_W/8-1:0]   s_keep,
    input  logic                  s_last,
    output logic                  mem_wr_rstn,
    output logic                  mem_wr_en,
    output logic [ADDR_W-1:0]     mem_wr_addr,
    output logic [DATA_W-1:0]     mem_wr_data,
    output logic                  mem_wr_last,
    input  logic                  m_clk,
    input  logic                  m_rstn,
    output logic                  m_valid,
    input  logic                  m_ready,
    output logic [DATA_W-1:0]     m_data,
    output logic [DATA_W/8-1:0]   m_keep,
    output logic                  m_last,
    output logic                  mem_rd_rstn,
    output logic                  mem_rd_en,
    input  logic                  mem_rd_rdy,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic [DATA_W-1:0]     mem_rd_data
);

    localparam int KEEP_W   = DATA_W / 8;
    localparam bit LOOP_OUT = TX_PATH && CYCLIC_EN;

    logic              push, hs_busy, frame_new;
    logic [ADDR_W-1:0] push_addr, frame_addr;
    logic [KEEP_W-1:0] push_keep, frame_keep;

    assign mem_wr_rstn = s_rstn;
    assign mem_rd_rstn = m_rstn;
    assign m_data      = mem_rd_data;

    offload_fill #(
        .DATA_W(DATA_W), .KEEP_W(KEEP_W), .ADDR_W(ADDR_W), .AUTO_START(AUTO_START)
    ) u_fill (
        .clk(s_clk), .rstn(s_rstn), .start_req(start_req),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_keep(s_keep), .s_last(s_last),
        .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .wr_last(mem_wr_last),
        .push(push), .push_addr(push_addr), .push_keep(push_keep), .hs_busy(hs_busy)
    );

    offload_xfer_sync #(
        .ADDR_W(ADDR_W), .KEEP_W(KEEP_W)
    ) u_xfer (
        .s_clk(s_clk), .s_rstn(s_rstn), .push(push), .push_addr(push_addr),
        .push_keep(push_keep), .busy(hs_busy),
        .m_clk(m_clk), .m_rstn(m_rstn), .frame_new(frame_new),
        .frame_addr(frame_addr), .frame_keep(frame_keep)
    );

    offload_play #(
        .ADDR_W(ADDR_W), .KEEP_W(KEEP_W), .CYCLIC(LOOP_OUT)
    ) u_play (
        .clk(m_clk), .rstn(m_rstn), .frame_new(frame_new),
        .frame_addr(frame_addr), .frame_keep(frame_keep),
        .m_ready(m_ready), .m_valid(m_valid), .m_last(m_last), .m_keep(m_keep),
        .rd_rdy(mem_rd_rdy), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr)
    );

endmodule

// File: tb/tb_offload_ctrl.sv
module tb_offload_ctrl;

    localparam int DW    = 16;
    localparam int KW    = DW / 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic s_clk = 1'b0;
    logic m_clk = 1'b0;
    always #10 s_clk = ~s_clk;   // 50 MHz
    always #17 m_clk = ~m_clk;

    logic s_rstn, m_rstn;
    logic          start_req [2];
    logic          s_valid   [2];
    logic          s_ready   [2];
    logic [DW-1:0] s_data    [2];
    logic [KW-1:0] s_keep    [2];
    logic          s_last    [2];
    logic          wr_rstn   [2];
    logic          wr_en     [2];
    logic [AW-1:0] wr_addr   [2];
    logic [DW-1:0] wr_data   [2];
    logic          wr_last   [2];
    logic          m_valid   [2];
    logic          m_ready   [2];
    logic [DW-1:0] m_data    [2];
    logic [KW-1:0] m_keep    [2];
    logic          m_last    [2];
    logic          rd_rstn   [2];
    logic          rd_en     [2];
    logic          rd_rdy    [2];
    logic [AW-1:0] rd_addr   [2];
    logic [DW-1:0] rd_q      [2];
    logic [DW-1:0] ram       [2][DEPTH];

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] exp_frame [2][DEPTH];
    int            exp_len   [2];
    logic [KW-1:0] exp_keep  [2];
    int            wcnt      [2];
    int            ocnt      [2];
    int            frames    [2];
    logic          held_v    [2];
    logic [DW-1:0] held_d    [2];
    logic          held_l    [2];
    logic [KW-1:0] held_k    [2];

    // transmit, looping, auto-started
    offload_ctrl #(.DATA_W(DW), .ADDR_W(AW), .TX_PATH(1'b1), .CYCLIC_EN(1'b1), .AUTO_START(1'b1)) dut (
        .s_clk(s_clk), .s_rstn(s_rstn), .start_req(start_req[0]),
        .s_valid(s_valid[0]), .s_ready(s_ready[0]), .s_data(s_data[0]),
        .s_keep(s_keep[0]), .s_last(s_last[0]),
        .mem_wr_rstn(wr_rstn[0]), .mem_wr_en(wr_en[0]), .mem_wr_addr(wr_addr[0]),
        .mem_wr_data(wr_data[0]), .mem_wr_last(wr_last[0]),
        .m_clk(m_clk), .m_rstn(m_rstn), .m_valid(m_valid[0]), .m_ready(m_ready[0]),
        .m_data(m_data[0]), .m_keep(m_keep[0]), .m_last(m_last[0]),
        .mem_rd_rstn(rd_rstn[0]), .mem_rd_en(rd_en[0]), .mem_rd_rdy(rd_rdy[0]),
        .mem_rd_addr(rd_addr[0]), .mem_rd_data(rd_q[0])
    );

    // receive, cyclic parameter set but must stay one-shot, request-armed
    offload_ctrl #(.DATA_W(DW), .ADDR_W(AW), .TX_PATH(1'b0), .CYCLIC_EN(1'b1), .AUTO_START(1'b0)) dut_rx (
        .s_clk(s_clk), .s_rstn(s_rstn), .start_req(start_req[1]),
        .s_valid(s_valid[1]), .s_ready(s_ready[1]), .s_data(s_data[1]),
        .s_keep(s_keep[1]), .s_last(s_last[1]),
        .mem_wr_rstn(wr_rstn[1]), .mem_wr_en(wr_en[1]), .mem_wr_addr(wr_addr[1]),
        .mem_wr_data(wr_data[1]), .mem_wr_last(wr_last[1]),
        .m_clk(m_clk), .m_rstn(m_rstn), .m_valid(m_valid[1]), .m_ready(m_ready[1]),
        .m_data(m_data[1]), .m_keep(m_keep[1]), .m_last(m_last[1]),
        .mem_rd_rstn(rd_rstn[1]), .mem_rd_en(rd_en[1]), .mem_rd_rdy(rd_rdy[1]),
        .mem_rd_addr(rd_addr[1]), .mem_rd_data(rd_q[1])
    );

    // RAM models: registered read that holds while not enabled
    always @(posedge s_clk)
        for (int k = 0; k < 2; k++)
            if (wr_en[k]) ram[k][wr_addr[k]] <= wr_data[k];

    always @(posedge m_clk)
        for (int k = 0; k < 2; k++)
            if (rd_en[k]) rd_q[k] <= ram[k][rd_addr[k]];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [KW-1:0] keep_for(input int k, input int idx);
        return (idx == exp_len[k] - 1) ? exp_keep[k] : {KW{1'b1}};
    endfunction

    // write-port monitor
    always @(negedge s_clk) begin
        if (s_rstn) begin
            for (int k = 0; k < 2; k++) begin
                if (wr_en[k]) begin
                    check("R2 write address", int'(wr_addr[k]), wcnt[k]);
                    check("R2 write data", int'(wr_data[k]), int'(exp_frame[k][wcnt[k]]));
                    check("R3/R5 write last", int'(wr_last[k]), int'(wcnt[k] == exp_len[k] - 1));
                    wcnt[k]++;
                end
            end
        end
    end

    // destination driver and monitor
    always @(negedge m_clk) begin
        if (m_rstn) begin
            for (int k = 0; k < 2; k++) begin
                m_ready[k] = ($urandom % 4) != 0;
                rd_rdy[k]  = ($urandom % 5) != 0;
            end
            #1;
            for (int k = 0; k < 2; k++) begin
                if (held_v[k]) begin
                    check("R11 hold valid", int'(m_valid[k]), 1);
                    check("R11 hold data", int'(m_data[k]), int'(held_d[k]));
                    check("R11 hold last/keep", int'({m_last[k], m_keep[k]}), int'({held_l[k], held_k[k]}));
                end
                if (!rd_rdy[k] && rd_en[k]) check("R11 read while not ready", 1, 0);
                held_v[k] = m_valid[k] && !m_ready[k];
                held_d[k] = m_data[k];
                held_l[k] = m_last[k];
                held_k[k] = m_keep[k];
                if (m_valid[k] && m_ready[k]) begin
                    check("R6 read data", int'(m_data[k]), int'(exp_frame[k][ocnt[k]]));
                    check("R9 last flag", int'(m_last[k]), int'(ocnt[k] == exp_len[k] - 1));
                    check("R7 keep", int'(m_keep[k]), int'(keep_for(k, ocnt[k])));
                    if (ocnt[k] >= exp_len[k] - 1) begin
                        ocnt[k] = 0;
                        frames[k]++;
                    end else begin
                        ocnt[k]++;
                    end
                end
            end
        end
    end

    task automatic pulse_start(input int k);
        @(negedge s_clk) start_req[k] = 1'b1;
        @(negedge s_clk) start_req[k] = 1'b0;
        check("R4 rearm ready", int'(s_ready[k]), 1);
    endtask

    task automatic send(input int k, input int n, input bit use_last, output int acc);
        int lim;
        logic [DW-1:0] d;
        logic [KW-1:0] kp;
        lim = (n > DEPTH) ? DEPTH : n;
        exp_len[k] = lim;
        wcnt[k] = 0;
        acc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge s_clk);
            if (($urandom % 4) == 0) begin
                s_valid[k] = 1'b0;
                @(negedge s_clk);
            end
            if (!s_ready[k]) break;
            d  = DW'($urandom);
            kp = KW'($urandom);
            if (i == lim - 1 && kp == '0) kp = 1;
            s_valid[k] = 1'b1;
            s_data[k]  = d;
            s_keep[k]  = kp;
            s_last[k]  = use_last && (i == n - 1);
            exp_frame[k][i] = d;
            if (i == lim - 1) exp_keep[k] = kp;
            acc++;
        end
        @(negedge s_clk);
        s_valid[k] = 1'b0;
        s_last[k]  = 1'b0;
    endtask

    task automatic wait_frames(input int k, input int target);
        for (int t = 0; t < 4000 && frames[k] < target; t++) @(negedge m_clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge s_clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int acc;
        int f0;
        void'($urandom(32'd2024));
        s_rstn = 1'b0;
        m_rstn = 1'b0;
        for (int k = 0; k < 2; k++) begin
            start_req[k] = 0; s_valid[k] = 0; s_data[k] = '0; s_keep[k] = '0;
            s_last[k] = 0; m_ready[k] = 0; rd_rdy[k] = 0;
            exp_len[k] = 1; exp_keep[k] = '1; wcnt[k] = 0; ocnt[k] = 0; frames[k] = 0;
            held_v[k] = 0; held_d[k] = '0; held_l[k] = 0; held_k[k] = '0;
        end
        repeat (5) @(negedge s_clk);
        s_rstn = 1'b1;
        @(negedge m_clk) m_rstn = 1'b1;
        @(negedge s_clk);
        // R1: reset state
        check("R1 ready auto-start", int'(s_ready[0]), 1);
        check("R1 ready request-armed", int'(s_ready[1]), 0);
        check("R1 no valid", int'(m_valid[0] | m_valid[1]), 0);
        check("R1 no strobes", int'(wr_en[0] | wr_en[1] | rd_en[0] | rd_en[1]), 0);

        // R9: looping playback of one partial-keep frame
        send(0, 7, 1'b1, acc);
        check("R2 beats accepted", acc, 7);
        repeat (10) @(negedge s_clk);
        check("R4 ready low after frame", int'(s_ready[0]), 0);
        wait_frames(0, 4);
        check("R9 repeated copies", int'(frames[0] >= 4), 1);

        // R10/R8: receive path plays once
        repeat (20) @(negedge s_clk);
        check("R4 stays unarmed", int'(s_ready[1]), 0);
        pulse_start(1);
        send(1, 5, 1'b1, acc);
        wait_frames(1, 1);
        repeat (60) @(negedge m_clk);
        check("R10 single copy", frames[1], 1);
        check("R8 valid low after copy", int'(m_valid[1]), 0);

        // R5: overrun past the top of memory
        pulse_start(1);
        send(1, 20, 1'b0, acc);
        check("R5 beats accepted", acc, DEPTH);
        check("R5 ready dropped", int'(s_ready[1]), 0);
        wait_frames(1, 2);
        repeat (60) @(negedge m_clk);
        check("R8 overrun single copy", frames[1], 2);

        // one-beat frame, then random lengths
        for (int r = 0; r < 4; r++) begin
            int len;
            len = (r == 0) ? 1 : 1 + int'($urandom % DEPTH);
            f0 = frames[1];
            pulse_start(1);
            send(1, len, 1'b1, acc);
            check("R2 random beats accepted", acc, len);
            wait_frames(1, f0 + 1);
            repeat (40) @(negedge m_clk);
            check("R8 random single copy", frames[1], f0 + 1);
            check("R8 idle after copy", int'(m_valid[1]), 0);
        end

        f0 = frames[0];
        wait_frames(0, f0 + 2);
        check("R9 still looping", int'(frames[0] >= f0 + 2), 1);

        summary();
        $finish;
    end

endmodule